// File: doc/BRIEF.md
# Two-Wire Write-Only Configuration Receiver

This block is a slave on a two-wire serial bus (SCL clock line, SDA data line) that can only be written. A bus master sends one fixed-length block write. The block samples both lines on its own system clock and recognises start and stop conditions. It checks a hard-wired 7-bit address and acknowledges each byte of a frame that targets it. It then loads a bank of configuration bytes that control clock outputs elsewhere on the chip.

The frame has ten bytes in a fixed order. The first is the address with the write bit. Two placeholder bytes follow, and the block ignores their values. Seven data bytes come last and land in register bytes 0 to 6. Every register byte has a reset default, so the chip runs correctly if the bus is never used. The whole bank is exported as a flat vector. Byte 0 is also decoded into named fields: test/high-impedance control, two 48/24 MHz selects, spread profile and spread enable. Bytes 1 to 6 hold per-output enable bits, where 1 lets an output run and 0 holds it low.

Top module: `cfg_serial_rx`

## Requirements
- R1: After reset, and after any asynchronous reset, the bank holds byte0..byte6 = 0x2C, 0xFF, 0x7F, 0xC3, 0x00, 0x00, 0x07 (cfg_o[8k+7:8k] is byte k), and sda_pull_o is 0.
- R2: A frame is a start condition followed by ten bytes: the address byte, two placeholder bytes, then data bytes 0 to 6. Data byte k is loaded into register byte k.
- R3: SDA is sampled on each rising edge of SCL, and the first bit of a byte is its bit 7 (MSB first).
- R4: Only the address byte 0xD2 (address 0x69 with write bit 0) is accepted. For any other value the block sends no acknowledge and changes no register until the next start condition.
- R5: In a frame with a matching address, sda_pull_o is 1 from the SCL falling edge after a byte's eighth bit until the following SCL falling edge. This holds for each of the ten bytes. At every other time sda_pull_o is 0.
- R6: The values of the two placeholder bytes never reach any register.
- R7: A data byte is committed on the SCL rising edge of its eighth bit. If a stop or a start arrives before that edge, the partial byte is dropped and bytes already committed in the frame are kept.
- R8: Bytes after the tenth are not acknowledged and change no register.
- R9: Byte 0 is decoded as follows: test_ctl_o = bits 1:0 (00 normal, 01 test, 11 high impedance), sel48_o = bits 3:2 (1 selects 48 MHz), spread_center_o = bit 4 (1 centre, 0 down), spread_en_o = bit 5.
- R10: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. SDA changes while SCL is low are data. A start in the middle of a frame restarts reception at the address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line from the bus master |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 drives SDA low (acknowledge); 0 releases the line |
| cfg_o | output | 8*DATA_BYTES | Register bank; byte k at bits 8k+7:8k |
| test_ctl_o | output | 2 | Byte 0 bits 1:0, test/high-impedance control |
| sel48_o | output | 2 | Byte 0 bits 3:2, per-output 48/24 MHz select |
| spread_center_o | output | 1 | Byte 0 bit 4, spread profile |
| spread_en_o | output | 1 | Byte 0 bit 5, spread enable |

## Verification
A behavioural model in the bench tracks the expected bank and the expected acknowledge, and the bench compares both on every settled clock.

The stimulus covers these cases:
- A full frame whose data bytes have single set bits at either end, which catches bit-order and byte-placement errors.
- Two wrong addresses, one differing only in the read/write bit, which separate address matching from plain byte reception.
- A frame whose placeholder bytes differ from every data byte, showing they are skipped.
- A stop inside a data byte and a repeated start inside a data byte, which test commit-at-eighth-bit and restart at the address byte.
- A frame two bytes too long, which checks that surplus bytes are not acknowledged.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_SETUP,
    ST_ACK_HOLD,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/cfg_rx_sync.sv
module cfg_rx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;   // idle bus is high
      else         chain <= {chain[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= '1;
    else         prev_o <= sync_o;
  end
endmodule

// File: rtl/cfg_rx_proto.sv
module cfg_rx_proto
  import cfg_rx_pkg::*;
#(
  parameter logic [6:0] ADDR       = 7'h69,
  parameter int         DATA_BYTES = 7,
  parameter int         SKIP_BYTES = 2,
  localparam int        IDX_W      = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             scl_q_i,
  input  logic             sda_q_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic             ack_o
);
  localparam int TOTAL      = 1 + SKIP_BYTES + DATA_BYTES;
  localparam int FIRST_DATA = 1 + SKIP_BYTES;
  localparam int CNT_W      = $clog2(TOTAL + 1);

  rx_state_e        state;
  logic [2:0]       bit_cnt;
  logic [CNT_W-1:0] byte_cnt;
  logic [6:0]       shreg;
  logic             addr_ok;

  logic scl_rise, scl_fall, start_det, stop_det, last_bit;
  logic [7:0] full_byte;

  assign scl_rise  = scl_i & ~scl_q_i;
  assign scl_fall  = ~scl_i & scl_q_i;
  // start/stop need SCL high on both samples
  assign start_det = scl_i & scl_q_i & sda_q_i & ~sda_i;
  assign stop_det  = scl_i & scl_q_i & ~sda_q_i & sda_i;
  assign last_bit  = (state == ST_RX) && scl_rise && (bit_cnt == 3'd7);
  assign full_byte = {shreg, sda_i};

  assign wr_en_o   = last_bit && addr_ok && (byte_cnt >= CNT_W'(FIRST_DATA));
  assign wr_idx_o  = IDX_W'(byte_cnt - CNT_W'(FIRST_DATA));
  assign wr_data_o = full_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      shreg    <= '0;
      addr_ok  <= 1'b0;
      ack_o    <= 1'b0;
    end else if (start_det) begin
      state    <= ST_RX;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      addr_ok  <= 1'b0;
      ack_o    <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      addr_ok  <= 1'b0;
      ack_o    <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: if (scl_rise) begin
          shreg   <= {shreg[5:0], sda_i};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            if (byte_cnt == '0) begin
              addr_ok <= (full_byte == {ADDR, 1'b0});
              state   <= (full_byte == {ADDR, 1'b0}) ? ST_ACK_SETUP : ST_SKIP;
            end else begin
              state   <= ST_ACK_SETUP;
            end
          end
        end
        ST_ACK_SETUP: if (scl_fall) begin
          ack_o <= 1'b1;
          state <= ST_ACK_HOLD;
        end
        ST_ACK_HOLD: if (scl_fall) begin
          ack_o    <= 1'b0;
          byte_cnt <= byte_cnt + CNT_W'(1);
          state    <= (byte_cnt == CNT_W'(TOTAL - 1)) ? ST_SKIP : ST_RX;
        end
        default: ;
      endcase
    end
  end

  AST_ACK_NEEDS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> addr_ok);  // R4
  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !ack_o);  // R5
  AST_ACK_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o ##1 ack_o |-> $past(scl_fall));  // R5
  AST_NO_ACK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE || state == ST_SKIP) |-> !ack_o);  // R8
endmodule

// File: rtl/cfg_rx_regs.sv
module cfg_rx_regs #(
  parameter int                      DATA_BYTES = 7,
  parameter logic [8*DATA_BYTES-1:0] DEFAULTS   = '0,
  localparam int                     IDX_W      = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [IDX_W-1:0]        wr_idx_i,
  input  logic [7:0]              wr_data_i,
  output logic [8*DATA_BYTES-1:0] bank_o
);
  logic [DATA_BYTES-1:0] sel;

  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_byte
    logic [7:0] q;
    assign sel[k] = wr_en_i && (wr_idx_i == IDX_W'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= DEFAULTS[8*k +: 8];
      else if (sel[k]) q <= wr_data_i;
    end
    assign bank_o[8*k +: 8] = q;
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (int'(wr_idx_i) < DATA_BYTES));  // R2
  AST_ONE_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));  // R2
  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(bank_o));  // R6
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx #(
  parameter int                      DATA_BYTES  = 7,
  parameter int                      SKIP_BYTES  = 2,
  parameter logic [6:0]              ADDR        = 7'h69,
  parameter int                      SYNC_STAGES = 2,
  parameter logic [8*DATA_BYTES-1:0] DEFAULTS    = 56'h07_00_00_C3_7F_FF_2C,
  localparam int                     IDX_W       = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_pull_o,
  output logic [8*DATA_BYTES-1:0] cfg_o,
  output logic [1:0]              test_ctl_o,
  output logic [1:0]              sel48_o,
  output logic                    spread_center_o,
  output logic                    spread_en_o
);
  logic [1:0]       line_s, line_q;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  cfg_rx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({scl_i, sda_i}),
    .sync_o  (line_s),
    .prev_o  (line_q)
  );

  cfg_rx_proto #(.ADDR(ADDR), .DATA_BYTES(DATA_BYTES), .SKIP_BYTES(SKIP_BYTES)) u_proto (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (line_s[1]),
    .sda_i     (line_s[0]),
    .scl_q_i   (line_q[1]),
    .sda_q_i   (line_q[0]),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx),
    .wr_data_o (wr_data),
    .ack_o     (sda_pull_o)
  );

  cfg_rx_regs #(.DATA_BYTES(DATA_BYTES), .DEFAULTS(DEFAULTS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .bank_o    (cfg_o)
  );

  assign test_ctl_o      = cfg_o[1:0];
  assign sel48_o         = cfg_o[3:2];
  assign spread_center_o = cfg_o[4];
  assign spread_en_o     = cfg_o[5];

  AST_PULL_NEEDS_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !line_s[1]);  // R5
endmodule

// File: tb/cfg_serial_rx_tb.sv
module cfg_serial_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PH         = 8;
  localparam logic [55:0] DEF = 56'h07_00_00_C3_7F_FF_2C;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda = 1'b1;
  logic        sda_pull;
  logic [55:0] cfg;
  logic [1:0]  test_ctl, sel48;
  logic        spread_center, spread_en;

  cfg_serial_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .sda_pull_o(sda_pull), .cfg_o(cfg), .test_ctl_o(test_ctl), .sel48_o(sel48),
    .spread_center_o(spread_center), .spread_en_o(spread_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] exp_cfg [7];
  logic exp_ack = 1'b0;
  int   m_byte = 0;
  bit   m_match = 0, m_active = 0;
  int   n_chk = 0, n_fail = 0, quiet = 0;
  logic scl_prev = 1'b1, sda_prev = 1'b1;

  function automatic logic [55:0] exp_flat();
    logic [55:0] f;
    for (int k = 0; k < 7; k++) f[8*k +: 8] = exp_cfg[k];
    return f;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic load_defaults();
    for (int k = 0; k < 7; k++) exp_cfg[k] = DEF[8*k +: 8];
    exp_ack = 1'b0; m_active = 0; m_match = 0; m_byte = 0;
  endtask

  // per-clock comparison against the model once the bus has settled
  always @(negedge clk) begin
    if (scl !== scl_prev || sda !== sda_prev) quiet = 0;
    else quiet++;
    scl_prev = scl; sda_prev = sda;
    if (rst_n && quiet >= 5) begin
      chk(cfg === exp_flat(), "R2/R7 bank", 64'(cfg), 64'(exp_flat()));
      chk(sda_pull === exp_ack, "R5 ack", 64'(sda_pull), 64'(exp_ack));
      chk({spread_en, spread_center, sel48, test_ctl} === exp_cfg[0][5:0], "R9 decode",
          64'({spread_en, spread_center, sel48, test_ctl}), 64'(exp_cfg[0][5:0]));
    end
  end

  task automatic wait_ph();
    repeat (PH) @(negedge clk);
  endtask

  task automatic bus_start();
    sda = 1'b1; wait_ph();
    scl = 1'b1; wait_ph();
    sda = 1'b0;                       // R10 start
    m_active = 1; m_match = 0; m_byte = 0; exp_ack = 1'b0;
    wait_ph();
    scl = 1'b0; wait_ph();
  endtask

  task automatic bus_stop();
    sda = 1'b0; wait_ph();
    scl = 1'b1; wait_ph();
    sda = 1'b1;
    m_active = 0; exp_ack = 1'b0;
    wait_ph(); wait_ph();
  endtask

  task automatic commit(input logic [7:0] b);
    if (!m_active) return;
    if (m_byte == 0) m_match = (b == 8'hD2);
    else if (m_match && m_byte >= 3 && m_byte <= 9) exp_cfg[m_byte-3] = b;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda = b[7-i]; wait_ph();        // R3 MSB first
      scl = 1'b1;
      if (i == 7) commit(b);
      wait_ph();
      scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
    exp_ack = m_active && m_match && (m_byte <= 9);
    sda = 1'b1; wait_ph();
    scl = 1'b1; repeat (PH/2) @(negedge clk);
    chk(sda_pull === exp_ack, "R5/R8 ninth-clock ack", 64'(sda_pull), 64'(exp_ack));
    repeat (PH/2) @(negedge clk);
    scl = 1'b0; exp_ack = 1'b0; m_byte++;
  endtask

  task automatic frame(input logic [7:0] a, input logic [7:0] c0, input logic [7:0] c1,
                       input logic [55:0] d);
    bus_start();
    send_byte(a); send_byte(c0); send_byte(c1);
    for (int k = 0; k < 7; k++) send_byte(d[8*k +: 8]);
  endtask

  initial begin
    load_defaults();
    repeat (5) @(negedge clk);
    chk(cfg === DEF, "R1 reset bank", 64'(cfg), 64'(DEF));
    chk(sda_pull === 1'b0, "R1 reset pull", 64'(sda_pull), 64'd0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // full frame, bit-order patterns
    frame(8'hD2, 8'hA5, 8'h3C, 56'hAA_55_0F_F0_01_80_13);
    bus_stop();
    chk(cfg === 56'hAA_55_0F_F0_01_80_13, "R2/R3 full frame", 64'(cfg), 64'hAA550FF0018013);
    chk({spread_en, spread_center, sel48, test_ctl} === 6'b010011, "R9 fields",
        64'({spread_en, spread_center, sel48, test_ctl}), 64'b010011);

    // wrong addresses
    frame(8'hD3, 8'h00, 8'h00, 56'h11_22_33_44_55_66_77);
    bus_stop();
    chk(cfg === 56'hAA_55_0F_F0_01_80_13, "R4 read-bit address", 64'(cfg), 64'hAA550FF0018013);
    frame(8'hD0, 8'h00, 8'h00, 56'h11_22_33_44_55_66_77);
    bus_stop();
    chk(cfg === 56'hAA_55_0F_F0_01_80_13, "R4 other address", 64'(cfg), 64'hAA550FF0018013);

    // placeholder bytes unlike any data byte
    frame(8'hD2, 8'hEE, 8'hDD, 56'h07_00_00_C3_7F_FF_21);
    bus_stop();
    chk(cfg[7:0] === 8'h21, "R6 placeholders skipped", 64'(cfg[7:0]), 64'h21);

    // stop inside data byte 2
    bus_start();
    send_byte(8'hD2); send_byte(8'h01); send_byte(8'h02);
    send_byte(8'h0C); send_byte(8'h42); send_bits(8'h99, 5);
    bus_stop();
    chk(cfg[23:0] === 24'h7F_42_0C, "R7 partial byte dropped", 64'(cfg[23:0]), 64'h7F420C);

    // repeated start inside data byte 1
    bus_start();
    send_byte(8'hD2); send_byte(8'h01); send_byte(8'h02);
    send_byte(8'h31); send_bits(8'h77, 3);
    bus_start();
    send_byte(8'hD2); send_byte(8'h05); send_byte(8'h06); send_byte(8'h24);
    bus_stop();
    chk(cfg[15:0] === 16'h42_24, "R10 restart at address", 64'(cfg[15:0]), 64'h4224);

    // two surplus bytes
    frame(8'hD2, 8'h00, 8'h00, 56'h01_02_03_04_05_06_2D);
    send_byte(8'hDE); send_byte(8'hAD);
    bus_stop();
    chk(cfg === 56'h01_02_03_04_05_06_2D, "R8 surplus bytes", 64'(cfg), 64'h0102030405062D);

    // asynchronous reset between frames
    rst_n = 1'b0; load_defaults();
    repeat (3) @(negedge clk);
    chk(cfg === DEF, "R1 reset again", 64'(cfg), 64'(DEF));
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule